// File: doc/BRIEF.md
# AES-128 Round Key Generator

This block turns a 128-bit cipher key into the eleven 128-bit round keys of the AES-128 schedule. It does not store the whole schedule. It holds one round key at a time and derives the next one on request. This lets it step in lockstep with a round-iterative encryption core. The core pulses a load strobe with the key, reads round key 0, and then pulses an advance strobe once per round. Each advance presents the next round key one cycle later.

The generator builds each new round key from the current one. Word 0 of the new key is the XOR of old word 0 with a transformed copy of old word 3. That copy is rotated left by one byte, passed byte by byte through the AES S-box, and XORed with the round constant on its most significant byte only. Each later word is the XOR of the matching old word with the new word just before it. The S-box is computed from its field definition, using the multiplicative inverse in GF(2^8) followed by the affine map. The round constant is held in a register and doubled in GF(2^8) on each step.

Top module: `aes_rkey_gen`

## Requirements
- R1: After reset, valid_o is 0, round_o is 0 and rkey_o is all zeros.
- R2: One cycle after load_i is high, rkey_o equals the key_i sampled with it, round_o is 0 and valid_o is 1. Key byte 0 sits in bits 127:120 and byte 15 in bits 7:0.
- R3: One cycle after an accepted advance_i (load_i low, valid_o high, round_o below 10), round_o grows by 1. In rkey_o each word equals the previous word of the new key XOR the same word of the old key, where word 0 is bits 127:96.
- R4: New word 0 is old word 0 XOR SubWord(RotWord(old word 3)) XOR (RC<<24). For key 2b7e151628aed2a6abf7158809cf4f3c, round key 1 is a0fafe1788542cb123a339392a6c7605 and round key 10 is d014f9a8c9ee2589e13f0cc8b6630ca6.
- R5: RC is 01 for round 1 and doubles in GF(2^8) with reduction 0x1B for each later round, giving 01,02,04,08,10,20,40,80,1B,36. For the all-zero key, round key 10 is b4ef5bcb3e92e21123e951cf6f8f188e.
- R6: advance_i at round 10 has no effect: rkey_o and round_o hold, and round_o never exceeds 10.
- R7: advance_i while valid_o is 0 has no effect: valid_o, round_o and rkey_o stay unchanged.
- R8: load_i takes priority over a simultaneous advance_i. Every load restarts RC at 01, so a reload after a partial expansion yields a correct schedule.
- R9: With neither strobe high, rkey_o, round_o and valid_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Capture key_i as round key 0 |
| key_i | input | 128 | Cipher key, byte 0 in the top bits |
| advance_i | input | 1 | Step to the next round key |
| rkey_o | output | 128 | Current round key |
| round_o | output | 4 | Index of the current round key, 0 to 10 |
| valid_o | output | 1 | Round key output holds a loaded schedule |

## Verification
The bench builds the block with its default ten-round setting. That setting makes the full eleven-key schedule reachable, along with the clamp at the last round. A behavioural model recomputes every round key from a byte-level S-box table, generated by its own field walk, and a list of words. The model is compared with the outputs each clock. Published schedules for a standard key and for the zero key anchor both ends. Reloads in mid-schedule and simultaneous strobes exercise the reset of the round constant.

// File: rtl/aes_ks_pkg.sv
package aes_ks_pkg;
  typedef logic [7:0]  byte_t;
  typedef logic [31:0] word_t;

  localparam int unsigned BLK_W   = 128;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned N_WORDS = BLK_W / WORD_W;
  localparam byte_t       GF_POLY = 8'h1b;
  localparam byte_t       RC_INIT = 8'h01;
  localparam byte_t       AFF_C   = 8'h63;

  function automatic byte_t xtime(byte_t a);
    return {a[6:0], 1'b0} ^ (a[7] ? GF_POLY : 8'h00);
  endfunction

  function automatic byte_t gf_mul(byte_t a, byte_t b);
    byte_t acc = 8'h00;
    byte_t x   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ x;
      x = xtime(x);
    end
    return acc;
  endfunction

  // x^254 = product of x^(2^k), k = 1..7; maps 0 to 0
  function automatic byte_t gf_inv(byte_t a);
    byte_t sq = a;
    byte_t r  = 8'h01;
    for (int k = 1; k < 8; k++) begin
      sq = gf_mul(sq, sq);
      r  = gf_mul(r, sq);
    end
    return r;
  endfunction

  function automatic byte_t rotl8(byte_t a, int unsigned n);
    return byte_t'((a << n) | (a >> (8 - n)));
  endfunction

  function automatic word_t rot_word(word_t w);
    return {w[23:0], w[31:24]};
  endfunction
endpackage

// File: rtl/aes_sbox_calc.sv
module aes_sbox_calc
  import aes_ks_pkg::*;
(
  input  byte_t in_i,
  output byte_t out_o
);
  byte_t inv;

  always_comb begin
    inv   = gf_inv(in_i);
    out_o = inv ^ rotl8(inv, 1) ^ rotl8(inv, 2) ^ rotl8(inv, 3) ^ rotl8(inv, 4) ^ AFF_C;
  end
endmodule

// File: rtl/aes_sub_word.sv
module aes_sub_word
  import aes_ks_pkg::*;
#(
  parameter int unsigned N_BYTES = 4
) (
  input  logic [8*N_BYTES-1:0] word_i,
  output logic [8*N_BYTES-1:0] word_o
);
  for (genvar g = 0; g < N_BYTES; g++) begin : g_sb
    aes_sbox_calc u_sbox (
      .in_i  (word_i[8*g +: 8]),
      .out_o (word_o[8*g +: 8])
    );
  end
endmodule

// File: rtl/aes_ks_step.sv
module aes_ks_step
  import aes_ks_pkg::*;
(
  input  logic [BLK_W-1:0] key_i,
  input  byte_t            rc_i,
  output logic [BLK_W-1:0] key_o
);
  localparam int unsigned LAST = N_WORDS - 1;

  word_t old_w [N_WORDS];
  word_t new_w [N_WORDS];
  word_t sub_w;
  word_t mix_w;

  for (genvar g = 0; g < N_WORDS; g++) begin : g_split
    assign old_w[g] = key_i[BLK_W-1-WORD_W*g -: WORD_W];
  end

  aes_sub_word #(.N_BYTES(WORD_W/8)) u_sub (
    .word_i (rot_word(old_w[LAST])),
    .word_o (sub_w)
  );

  assign mix_w    = sub_w ^ {rc_i, 24'h0};
  assign new_w[0] = old_w[0] ^ mix_w;

  for (genvar g = 1; g < N_WORDS; g++) begin : g_chain
    assign new_w[g] = old_w[g] ^ new_w[g-1];
  end

  for (genvar g = 0; g < N_WORDS; g++) begin : g_join
    assign key_o[BLK_W-1-WORD_W*g -: WORD_W] = new_w[g];
  end
endmodule

// File: rtl/aes_rkey_gen.sv
module aes_rkey_gen
  import aes_ks_pkg::*;
#(
  parameter int unsigned N_ROUNDS = 10,
  localparam int unsigned RND_W   = $clog2(N_ROUNDS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [127:0]     key_i,
  input  logic             advance_i,
  output logic [127:0]     rkey_o,
  output logic [RND_W-1:0] round_o,
  output logic             valid_o
);
  localparam logic [RND_W-1:0] LAST_RND = RND_W'(N_ROUNDS);

  logic [BLK_W-1:0] key_q, key_nxt;
  logic [RND_W-1:0] rnd_q;
  byte_t            rc_q;
  logic             vld_q;
  logic             step;

  assign step = advance_i && !load_i && vld_q && (rnd_q != LAST_RND);

  aes_ks_step u_step (
    .key_i (key_q),
    .rc_i  (rc_q),
    .key_o (key_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q <= '0;
      rnd_q <= '0;
      rc_q  <= RC_INIT;
      vld_q <= 1'b0;
    end else if (load_i) begin
      key_q <= key_i;
      rnd_q <= '0;
      rc_q  <= RC_INIT;
      vld_q <= 1'b1;
    end else if (step) begin
      key_q <= key_nxt;
      rnd_q <= rnd_q + 1'b1;
      rc_q  <= xtime(rc_q);
    end
  end

  assign rkey_o  = key_q;
  assign round_o = rnd_q;
  assign valid_o = vld_q;
endmodule

// File: rtl/aes_rkey_gen_chk.sv
module aes_rkey_gen_chk #(
  parameter int unsigned N_ROUNDS = 10,
  localparam int unsigned RND_W   = $clog2(N_ROUNDS + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_i,
  input logic [127:0]     key_i,
  input logic             advance_i,
  input logic [127:0]     rkey_o,
  input logic [RND_W-1:0] round_o,
  input logic             valid_o
);
  localparam logic [RND_W-1:0] LAST_RND = RND_W'(N_ROUNDS);

  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> valid_o && round_o == '0 && rkey_o == $past(key_i));

  p_step_round_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance_i && !load_i && valid_o && round_o != LAST_RND) |=> round_o == $past(round_o) + 1'b1);

  p_chain_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance_i && !load_i && valid_o && round_o != LAST_RND) |=>
      rkey_o[95:64] == (rkey_o[127:96] ^ $past(rkey_o[95:64])) &&
      rkey_o[31:0]  == (rkey_o[63:32]  ^ $past(rkey_o[31:0])));

  p_clamp_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (advance_i && !load_i && round_o == LAST_RND) |=> $stable(rkey_o) && $stable(round_o));

  p_max_round_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    round_o <= LAST_RND);

  p_idle_adv_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o && !load_i) |=> !valid_o && $stable(rkey_o) && $stable(round_o));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !advance_i) |=> $stable(rkey_o) && $stable(round_o) && $stable(valid_o));
endmodule

bind aes_rkey_gen aes_rkey_gen_chk #(.N_ROUNDS(N_ROUNDS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .load_i    (load_i),
  .key_i     (key_i),
  .advance_i (advance_i),
  .rkey_o    (rkey_o),
  .round_o   (round_o),
  .valid_o   (valid_o)
);

// File: tb/aes_rkey_gen_bench.sv
module aes_rkey_gen_bench;
  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         load_i = 1'b0;
  logic [127:0] key_i = '0;
  logic         advance_i = 1'b0;
  logic [127:0] rkey_o;
  logic [3:0]   round_o;
  logic         valid_o;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 1'b0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  aes_rkey_gen u_aes_rkey_gen (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .load_i    (load_i),
    .key_i     (key_i),
    .advance_i (advance_i),
    .rkey_o    (rkey_o),
    .round_o   (round_o),
    .valid_o   (valid_o)
  );

  // reference model state
  int unsigned sbox_t [256];
  int unsigned m_w [$];
  int unsigned m_rc;
  int          m_round;
  bit          m_valid;
  string       m_tag = "R1";

  function automatic int unsigned rl8(int unsigned v, int n);
    return ((v << n) | (v >> (8 - n))) & 8'hff;
  endfunction

  function automatic void build_sbox();
    int unsigned p = 1, q = 1, x;
    do begin
      p = (p ^ (p << 1) ^ (((p & 8'h80) != 0) ? 8'h1b : 0)) & 8'hff;
      q = (q ^ (q << 1)) & 8'hff;
      q = (q ^ (q << 2)) & 8'hff;
      q = (q ^ (q << 4)) & 8'hff;
      if ((q & 8'h80) != 0) q = q ^ 8'h09;
      x = q ^ rl8(q, 1) ^ rl8(q, 2) ^ rl8(q, 3) ^ rl8(q, 4);
      sbox_t[p] = (x ^ 8'h63) & 8'hff;
    end while (p != 1);
    sbox_t[0] = 8'h63;
  endfunction

  function automatic logic [127:0] model_key();
    return {m_w[0][31:0], m_w[1][31:0], m_w[2][31:0], m_w[3][31:0]};
  endfunction

  function automatic void model_step();
    int unsigned t = m_w[3];
    int unsigned r;
    int unsigned nw [$];
    r = ((t << 8) | (t >> 24));
    t = (sbox_t[(r >> 24) & 8'hff] << 24) | (sbox_t[(r >> 16) & 8'hff] << 16) |
        (sbox_t[(r >> 8) & 8'hff] << 8) | sbox_t[r & 8'hff];
    t = t ^ (m_rc << 24);
    for (int i = 0; i < 4; i++) begin
      t = m_w[i] ^ t;
      nw.push_back(t);
    end
    m_w  = nw;
    m_rc = ((m_rc << 1) ^ (((m_rc & 8'h80) != 0) ? 8'h1b : 0)) & 8'hff;
    m_round++;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_w = '{0, 0, 0, 0};
      m_rc = 1; m_round = 0; m_valid = 0;
    end else if (load_i) begin
      m_w = '{key_i[127:96], key_i[95:64], key_i[63:32], key_i[31:0]};
      m_rc = 1; m_round = 0; m_valid = 1;
    end else if (advance_i && m_valid && m_round < 10) begin
      model_step();
    end
  end

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && rst_ni && !done) begin
      chk({m_tag, " key"}, rkey_o, model_key());
      chk({m_tag, " round"}, 128'(round_o), 128'(m_round));
      chk({m_tag, " valid"}, 128'(valid_o), 128'(m_valid));
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_load(logic [127:0] k, bit with_adv = 0);
    load_i = 1; key_i = k; advance_i = with_adv;
    tick();
    load_i = 0; advance_i = 0;
  endtask

  task automatic do_adv(int n, int gap = 0);
    for (int i = 0; i < n; i++) begin
      advance_i = 1; tick();
      advance_i = 0;
      if (gap > 0) tick(gap);
    end
  endtask

  localparam logic [127:0] STD_KEY = 128'h2b7e151628aed2a6abf7158809cf4f3c;

  initial begin
    build_sbox();
    #35;
    tick();
    chk("R1 reset key", rkey_o, '0);
    chk("R1 reset round", 128'(round_o), 0);
    chk("R1 reset valid", 128'(valid_o), 0);
    rst_ni = 1;
    cmp_on = 1;
    tick();

    m_tag = "R7";
    do_adv(3);
    chk("R7 idle advance valid", 128'(valid_o), 0);
    chk("R7 idle advance key", rkey_o, '0);

    m_tag = "R2";
    do_load(STD_KEY);
    chk("R2 load key", rkey_o, STD_KEY);
    chk("R2 load round", 128'(round_o), 0);

    m_tag = "R4";
    do_adv(1);
    chk("R4 round 1 std key", rkey_o, 128'ha0fafe1788542cb123a339392a6c7605);
    m_tag = "R9";
    tick(4);
    chk("R9 hold key", rkey_o, 128'ha0fafe1788542cb123a339392a6c7605);
    m_tag = "R3";
    do_adv(4, 2);
    do_adv(5);
    chk("R4 round 10 std key", rkey_o, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);
    chk("R3 round index 10", 128'(round_o), 10);

    m_tag = "R6";
    do_adv(3);
    chk("R6 clamp key", rkey_o, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);
    chk("R6 clamp round", 128'(round_o), 10);

    m_tag = "R5";
    do_load('0);
    do_adv(10);
    chk("R5 zero key round 10", rkey_o, 128'hb4ef5bcb3e92e21123e951cf6f8f188e);

    m_tag = "R8";
    do_load(128'h000102030405060708090a0b0c0d0e0f);
    do_adv(4);
    do_load(STD_KEY, 1);
    chk("R8 load beats advance key", rkey_o, STD_KEY);
    chk("R8 load beats advance round", 128'(round_o), 0);
    do_adv(1);
    chk("R8 reload RC restart", rkey_o, 128'ha0fafe1788542cb123a339392a6c7605);
    m_tag = "R3";
    do_load(128'hffeeddccbbaa99887766554433221100);
    do_adv(10, 1);
    tick(2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule